// File: doc/BRIEF.md
# Dual-Handshake Parallel ADC Read Controller

This block sits on the host side of an 8-bit parallel analog-to-digital converter. It drives the converter's active-low chip-select, read and write strobes, and it watches two lines that the converter drives back: an active-low interrupt and a ready line, which reads low while a conversion is in progress and high once it has been released. A one-cycle start request begins a conversion. When the result has been captured, the block presents it on `data_o` with a one-cycle `valid_o` pulse.

Two converter handshakes share one sequencing engine, and a static mode input selects between them. In read-started mode, chip-select and read fall together and stay low, so the host is stalled, until the ready line has gone low and then been released. In write-started mode, a write pulse starts the conversion and a read pulse then fetches the result. The read pulse is launched at one of three points:
- when the interrupt falls;
- after a fixed early-read delay, with the interrupt ignored;
- in standalone use, after a fixed settle delay, with chip-select and read held low for the whole transaction.

Every delay is given in nanoseconds and rounded up to whole clock cycles. Both returning lines pass through a two-flop synchroniser. Any wait on a returning line is bounded by a timeout, which aborts the conversion and raises an error flag.

Top module: `adc_hs_ctrl`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `cs_n_o`, `rd_n_o` and `wr_n_o` are high and `busy_o`, `valid_o` and `err_o` are low.
- R2: With `mode_i`=0 (read-started), chip-select and read fall in the same cycle, the cycle after `start_i` is seen. Both stay low until the read access ends and rise together. Write stays high for the whole transaction.
- R3: In read-started mode, the read access begins only after the synchronised ready line has been seen low and then high. The captured byte is the value the converter presents after releasing ready.
- R4: With `mode_i`=1 (write-started), chip-select is low whenever write is low. Write is held low for exactly ceil(WR_NS/CLK_NS) cycles, which is 5 with the defaults.
- R5: With `mode_i`=1, `fast_i`=0 and `solo_i`=0, read falls 2 to 4 cycles after the interrupt falls, and never before it. The byte captured is the one latched at interrupt time.
- R6: With `mode_i`=1, `fast_i`=1 and `solo_i`=0, read falls exactly ceil(EARLY_NS/CLK_NS) cycles after write rises, which is 13 with the defaults. The interrupt has no effect on this timing.
- R7: With `mode_i`=1 and `solo_i`=1, whatever the value of `fast_i`, chip-select and read fall together at the start and stay low. Exactly one write pulse is issued. Chip-select and read rise ceil(SOLO_NS/CLK_NS) cycles after write rises, which is 27 with the defaults.
- R8: In the interrupt and early-read options, read stays low for exactly ceil(ACC_NS/CLK_NS) cycles, which is 3 with the defaults. The byte is sampled on the last of those cycles.
- R9: `valid_o` is a single-cycle pulse, issued in the first cycle after the read access in which all strobes are high. `data_o` then carries the captured byte.
- R10: If a wait on ready or the interrupt exceeds TIMEOUT_CYC cycles, `err_o` rises, all strobes return high and no `valid_o` is issued. `err_o` clears when the next start is accepted.
- R11: `busy_o` is high from the cycle after an accepted start until the controller returns idle. A `start_i` that arrives while busy is ignored and causes no second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| mode_i | input | 1 | 0 read-started, 1 write-started (static) |
| fast_i | input | 1 | Write-started: 1 reads on the early-read timer |
| solo_i | input | 1 | Write-started: 1 standalone, overrides fast_i |
| rdy_i | input | 1 | Converter ready line, low while converting |
| int_n_i | input | 1 | Converter interrupt, active low |
| data_i | input | DATA_W | Converter data outputs |
| cs_n_o | output | 1 | Chip-select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Timeout abort flag |
| data_o | output | DATA_W | Captured result |

## Verification
A converter model drives the ready, interrupt and data lines, and it puts a marker byte on the bus until its conversion finishes. Read-started transactions with short and long conversions show whether the controller waits for both the low and the high phase of ready. In the interrupt option, one run has a conversion longer than the early-read delay and another has a shorter one: an early read returns the marker byte, which separates the interrupt wait from the early-read option. The early-read and standalone runs measure the strobe edge distances against the rounded-up delays, and standalone is also run with `fast_i` set to check that it takes precedence. A converter that never answers covers the timeout, and a second start issued mid-conversion covers the busy rule.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_ARM,
      ST_RD_WAIT,
      ST_WR_PULSE,
      ST_INT_WAIT,
      ST_GAP,
      ST_RD_ACC,
      ST_DONE
   } hs_state_e;

   typedef struct packed {
      logic cs_n;
      logic rd_n;
      logic wr_n;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int per_ns);
      int c;
      c = (ns + per_ns - 1) / per_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{{W{RST_VAL}}}};
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/adc_hs_cdown.sv
module adc_hs_cdown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   input  logic         en_i,
   output logic         last_o
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_i) begin
         cnt <= val_i;
      end else if (en_i && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   // final cycle of a loaded interval (zero also counts as expired)
   assign last_o = (cnt <= W'(1));

endmodule

// File: rtl/adc_hs_fsm.sv
module adc_hs_fsm
   import adc_hs_pkg::*;
#(
   parameter int CW          = 6,
   parameter int WR_CYC      = 5,
   parameter int EARLY_CYC   = 13,
   parameter int SOLO_CYC    = 27,
   parameter int ACC_CYC     = 3,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic          fast_i,
   input  logic          solo_i,
   input  logic          rdy_s_i,
   input  logic          int_n_s_i,
   input  logic          t_last_i,
   input  logic          tmo_last_i,
   output logic          t_load_o,
   output logic [CW-1:0] t_val_o,
   output logic          tmo_load_o,
   output logic          tmo_en_o,
   output logic          cap_o,
   output strobe_t       strobe_o,
   output logic          busy_o,
   output logic          valid_o,
   output logic          err_o
);

   localparam logic [CW-1:0] WR_V    = CW'(WR_CYC);
   localparam logic [CW-1:0] EARLY_V = CW'(EARLY_CYC);
   localparam logic [CW-1:0] SOLO_V  = CW'(SOLO_CYC);
   localparam logic [CW-1:0] ACC_V   = CW'(ACC_CYC);

   hs_state_e st_q, st_d;
   logic      mode_q, fast_q, solo_q;
   logic      solo_d;
   logic      accept, abort;
   logic      err_q;

   function automatic strobe_t decode(input hs_state_e s, input logic solo);
      strobe_t o;
      o = STROBE_IDLE;
      case (s)
         ST_RD_ARM, ST_RD_WAIT, ST_RD_ACC: begin
            o.cs_n = 1'b0;
            o.rd_n = 1'b0;
         end
         ST_WR_PULSE: begin
            o.cs_n = 1'b0;
            o.wr_n = 1'b0;
            o.rd_n = ~solo;
         end
         ST_INT_WAIT: o.cs_n = 1'b0;
         ST_GAP: begin
            o.cs_n = 1'b0;
            o.rd_n = ~solo;
         end
         default: o = STROBE_IDLE;
      endcase
      return o;
   endfunction

   assign accept = (st_q == ST_IDLE) && start_i;
   assign solo_d = accept ? solo_i : solo_q;

   always_comb begin
      st_d     = st_q;
      t_load_o = 1'b0;
      t_val_o  = '0;
      tmo_en_o = 1'b0;
      cap_o    = 1'b0;
      abort    = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (mode_i) begin
                  st_d     = ST_WR_PULSE;
                  t_load_o = 1'b1;
                  t_val_o  = WR_V;
               end else begin
                  st_d = ST_RD_ARM;
               end
            end
         end
         ST_RD_ARM: begin
            tmo_en_o = 1'b1;
            if (!rdy_s_i)        st_d  = ST_RD_WAIT;
            else if (tmo_last_i) abort = 1'b1;
         end
         ST_RD_WAIT: begin
            tmo_en_o = 1'b1;
            if (rdy_s_i) begin
               st_d     = ST_RD_ACC;
               t_load_o = 1'b1;
               t_val_o  = ACC_V;
            end else if (tmo_last_i) begin
               abort = 1'b1;
            end
         end
         ST_WR_PULSE: begin
            if (t_last_i) begin
               if (solo_q) begin
                  st_d     = ST_GAP;
                  t_load_o = 1'b1;
                  t_val_o  = SOLO_V;
               end else if (fast_q) begin
                  st_d     = ST_GAP;
                  t_load_o = 1'b1;
                  t_val_o  = EARLY_V;
               end else begin
                  st_d = ST_INT_WAIT;
               end
            end
         end
         ST_INT_WAIT: begin
            tmo_en_o = 1'b1;
            if (!int_n_s_i) begin
               st_d     = ST_RD_ACC;
               t_load_o = 1'b1;
               t_val_o  = ACC_V;
            end else if (tmo_last_i) begin
               abort = 1'b1;
            end
         end
         ST_GAP: begin
            if (t_last_i) begin
               if (solo_q) begin
                  cap_o = 1'b1;
                  st_d  = ST_DONE;
               end else begin
                  st_d     = ST_RD_ACC;
                  t_load_o = 1'b1;
                  t_val_o  = ACC_V;
               end
            end
         end
         ST_RD_ACC: begin
            if (t_last_i) begin
               cap_o = 1'b1;
               st_d  = ST_DONE;
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
      if (abort) st_d = ST_IDLE;
   end

   assign tmo_load_o = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= 1'b0;
         fast_q <= 1'b0;
         solo_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            mode_q <= mode_i;
            fast_q <= fast_i;
            solo_q <= solo_i;
         end
         if (accept)     err_q <= 1'b0;
         else if (abort) err_q <= 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         strobe_t strobe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) strobe_q <= STROBE_IDLE;
            else        strobe_q <= decode(st_d, solo_d);
         end
         assign strobe_o = strobe_q;
      end else begin : g_out_comb
         assign strobe_o = decode(st_q, solo_q);
      end
   endgenerate

   assign busy_o  = (st_q != ST_IDLE);
   assign valid_o = (st_q == ST_DONE);
   assign err_o   = err_q;

   // mode_q is captured for the read-started path; it selects no branch
   // beyond the start decision but keeps the latched set complete
   logic mode_unused;
   assign mode_unused = mode_q;

endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
   import adc_hs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_NS      = 20,
   parameter int WR_NS       = 100,
   parameter int EARLY_NS    = 250,
   parameter int SOLO_NS     = 530,
   parameter int ACC_NS      = 60,
   parameter int TIMEOUT_CYC = 200,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic              fast_i,
   input  logic              solo_i,
   input  logic              rdy_i,
   input  logic              int_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              busy_o,
   output logic              valid_o,
   output logic              err_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int WR_CYC    = ns_to_cyc(WR_NS, CLK_NS);
   localparam int EARLY_CYC = ns_to_cyc(EARLY_NS, CLK_NS);
   localparam int SOLO_CYC  = ns_to_cyc(SOLO_NS, CLK_NS);
   localparam int ACC_CYC   = ns_to_cyc(ACC_NS, CLK_NS);
   localparam int MAX_CYC   = max4(WR_CYC, EARLY_CYC, SOLO_CYC, ACC_CYC);
   localparam int CW        = $clog2(MAX_CYC + 1);
   localparam int TW        = $clog2(TIMEOUT_CYC + 1);

   generate
      if (DATA_W < 1) begin : g_chk_dw
         $error("adc_hs_ctrl: DATA_W must be at least 1");
      end
      if (CLK_NS < 1) begin : g_chk_clk
         $error("adc_hs_ctrl: CLK_NS must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("adc_hs_ctrl: SYNC_STAGES must be at least 2");
      end
      if (WR_CYC < SYNC_STAGES) begin : g_chk_wr
         $error("adc_hs_ctrl: write pulse must outlast the synchroniser");
      end
      if (TIMEOUT_CYC < 2) begin : g_chk_tmo
         $error("adc_hs_ctrl: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic [1:0]    line_raw, line_s;
   logic          rdy_s, int_n_s;
   logic          t_load, t_last, tmo_load, tmo_en, tmo_last, cap;
   logic [CW-1:0] t_val;
   strobe_t       strobe;
   logic [DATA_W-1:0] data_q;

   assign line_raw = {rdy_i, int_n_i};

   adc_hs_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_raw),
      .q_o   (line_s)
   );

   assign rdy_s   = line_s[1];
   assign int_n_s = line_s[0];

   adc_hs_cdown #(.W(CW)) u_phase_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (t_load),
      .val_i  (t_val),
      .en_i   (1'b1),
      .last_o (t_last)
   );

   adc_hs_cdown #(.W(TW)) u_wait_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmo_load),
      .val_i  (TW'(TIMEOUT_CYC)),
      .en_i   (tmo_en),
      .last_o (tmo_last)
   );

   adc_hs_fsm #(
      .CW        (CW),
      .WR_CYC    (WR_CYC),
      .EARLY_CYC (EARLY_CYC),
      .SOLO_CYC  (SOLO_CYC),
      .ACC_CYC   (ACC_CYC),
      .OUT_REG   (OUT_REG)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .mode_i     (mode_i),
      .fast_i     (fast_i),
      .solo_i     (solo_i),
      .rdy_s_i    (rdy_s),
      .int_n_s_i  (int_n_s),
      .t_last_i   (t_last),
      .tmo_last_i (tmo_last),
      .t_load_o   (t_load),
      .t_val_o    (t_val),
      .tmo_load_o (tmo_load),
      .tmo_en_o   (tmo_en),
      .cap_o      (cap),
      .strobe_o   (strobe),
      .busy_o     (busy_o),
      .valid_o    (valid_o),
      .err_o      (err_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   data_q <= '0;
      else if (cap) data_q <= data_i;
   end

   assign cs_n_o = strobe.cs_n;
   assign rd_n_o = strobe.rd_n;
   assign wr_n_o = strobe.wr_n;
   assign data_o = data_q;

endmodule

// File: rtl/adc_hs_ctrl_chk.sv
module adc_hs_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic mode_i,
   input logic cs_n_o,
   input logic rd_n_o,
   input logic wr_n_o,
   input logic busy_o,
   input logic valid_o,
   input logic err_o
);

   assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && rd_n_o && wr_n_o));

   assert_rd_mode_no_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !mode_i) |-> wr_n_o);

   assert_wr_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> !cs_n_o);

   assert_valid_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(!rd_n_o));

   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_valid_strobes_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (cs_n_o && rd_n_o && wr_n_o));

   assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (cs_n_o && rd_n_o && wr_n_o && !valid_o && !busy_o));

   assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

endmodule

bind adc_hs_ctrl adc_hs_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .mode_i  (mode_i),
   .cs_n_o  (cs_n_o),
   .rd_n_o  (rd_n_o),
   .wr_n_o  (wr_n_o),
   .busy_o  (busy_o),
   .valid_o (valid_o),
   .err_o   (err_o)
);

// File: tb/adc_hs_ctrl_bench.sv
module adc_hs_ctrl_bench;

   localparam int CLK_NS    = 20;
   localparam int WR_EXP    = (100 + CLK_NS - 1) / CLK_NS;
   localparam int EARLY_EXP = (250 + CLK_NS - 1) / CLK_NS;
   localparam int SOLO_EXP  = (530 + CLK_NS - 1) / CLK_NS;
   localparam int ACC_EXP   = (60 + CLK_NS - 1) / CLK_NS;

   typedef struct {
      bit         err;
      logic [7:0] d;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, mode_i = 1'b0, fast_i = 1'b0, solo_i = 1'b0;
   logic       rdy_i = 1'b1, int_n_i = 1'b1;
   logic [7:0] bus = 8'h00;
   logic       cs_n, rd_n, wr_n, busy, valid, err;
   logic [7:0] data_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   exp_t sb[$];

   always #(CLK_NS/2) clk = ~clk;

   adc_hs_ctrl u_adc_hs_ctrl (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
      .fast_i (fast_i), .solo_i (solo_i), .rdy_i (rdy_i), .int_n_i (int_n_i),
      .data_i (bus), .cs_n_o (cs_n), .rd_n_o (rd_n), .wr_n_o (wr_n),
      .busy_o (busy), .valid_o (valid), .err_o (err), .data_o (data_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // cycle counter and edge timestamps, sampled away from the active edge
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  t_cs_fall, t_cs_rise, t_rd_fall, t_rd_rise, t_wr_fall, t_wr_rise, t_int;
   int  n_wr_pulses, n_rd_rises;
   logic p_cs = 1'b1, p_rd = 1'b1, p_wr = 1'b1;

   always @(negedge clk) begin
      if (!cs_n && p_cs) t_cs_fall = cyc;
      if (cs_n && !p_cs) t_cs_rise = cyc;
      if (!rd_n && p_rd) t_rd_fall = cyc;
      if (rd_n && !p_rd) begin t_rd_rise = cyc; n_rd_rises++; end
      if (!wr_n && p_wr) begin t_wr_fall = cyc; n_wr_pulses++; end
      if (wr_n && !p_wr) t_wr_rise = cyc;
      p_cs = cs_n; p_rd = rd_n; p_wr = wr_n;
   end

   // converter model
   bit         m_dead = 0;
   int         m_conv = 10;
   logic [7:0] m_sample = 8'h00;
   int         mcnt = 0;
   logic       mp_cs = 1'b1, mp_rd = 1'b1, mp_wr = 1'b1;

   always @(negedge clk) begin
      if (rst_n && !m_dead) begin
         if ((cs_n && !mp_cs) || (rd_n && !mp_rd)) int_n_i = 1'b1;
         if (!mode_i) begin
            if (!cs_n && !rd_n && (mp_cs || mp_rd)) begin
               rdy_i = 1'b0; bus = 8'hEE; mcnt = m_conv;
            end else if (mcnt != 0) begin
               mcnt--;
               if (mcnt == 0) begin rdy_i = 1'b1; bus = m_sample; int_n_i = 1'b0; end
            end
         end else begin
            if (!cs_n && wr_n && !mp_wr) begin
               bus = 8'hEE; mcnt = m_conv;
            end else if (mcnt != 0) begin
               mcnt--;
               if (mcnt == 0) begin
                  bus = m_sample;
                  if (!fast_i) begin int_n_i = 1'b0; t_int = cyc; end
               end
            end
            if (fast_i && !solo_i && !cs_n && !rd_n && mp_rd) int_n_i = 1'b0;
         end
      end
      mp_cs = cs_n; mp_rd = rd_n; mp_wr = wr_n;
   end

   // scoreboard monitor
   logic p_err = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (valid) begin
            if (sb.size() == 0) check(0, "R11 unexpected valid", 1, 0);
            else begin
               exp_t e;
               e = sb.pop_front();
               check(!e.err, "R10 valid where abort expected", 1, 0);
               check(data_o === e.d, "R9 R3 captured data", data_o, e.d);
            end
         end
         if (err && !p_err) begin
            if (sb.size() == 0) check(0, "R10 unexpected error", 1, 0);
            else begin
               exp_t e;
               e = sb.pop_front();
               check(e.err, "R10 abort where data expected", 1, 0);
            end
         end
         p_err = err;
      end
   end

   task automatic run(input bit m, input bit f, input bit s, input logic [7:0] v,
                      input bit dead, input int conv, input bit dup);
      exp_t e;
      @(negedge clk);
      mode_i = m; fast_i = f; solo_i = s;
      m_dead = dead; m_conv = conv; m_sample = v;
      n_wr_pulses = 0; n_rd_rises = 0; t_int = -1000;
      e.err = dead; e.d = v;
      sb.push_back(e);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy == 1'b1, "R11 busy after start", busy, 1);
      if (dup) begin
         repeat (4) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      check(busy == 1'b0, "R11 returns idle", busy, 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && rd_n && wr_n, "R1 strobes high in reset", {cs_n, rd_n, wr_n}, 7);
      check(!busy && !valid && !err, "R1 flags low in reset", {busy, valid, err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cs_n && rd_n && wr_n, "R1 strobes high after reset", {cs_n, rd_n, wr_n}, 7);
      check(!busy && !valid && !err, "R1 flags low after reset", {busy, valid, err}, 0);

      // read-started mode, short and long conversions
      run(0, 0, 0, 8'hA5, 0, 10, 0);
      check(t_cs_fall == t_rd_fall, "R2 cs and rd fall together", t_rd_fall, t_cs_fall);
      check(t_cs_rise == t_rd_rise, "R2 cs and rd rise together", t_rd_rise, t_cs_rise);
      check(n_wr_pulses == 0, "R2 no write in read mode", n_wr_pulses, 0);
      check(t_rd_rise - t_rd_fall > 10, "R3 read held through conversion", t_rd_rise - t_rd_fall, 11);
      run(0, 0, 0, 8'hFF, 0, 30, 0);
      check(t_rd_rise - t_rd_fall > 30, "R3 long conversion stall", t_rd_rise - t_rd_fall, 31);

      // write-started, interrupt option: long then short conversion
      run(1, 0, 0, 8'h5A, 0, 40, 0);
      check(t_wr_rise - t_wr_fall == WR_EXP, "R4 write width", t_wr_rise - t_wr_fall, WR_EXP);
      check(n_wr_pulses == 1, "R4 one write pulse", n_wr_pulses, 1);
      check(t_rd_fall - t_int >= 2 && t_rd_fall - t_int <= 4, "R5 read after interrupt",
            t_rd_fall - t_int, 3);
      check(t_rd_rise - t_rd_fall == ACC_EXP, "R8 read width", t_rd_rise - t_rd_fall, ACC_EXP);
      run(1, 0, 0, 8'hC3, 0, 6, 0);
      check(t_rd_fall - t_int >= 2 && t_rd_fall - t_int <= 4, "R5 short conversion",
            t_rd_fall - t_int, 3);

      // early-read option
      run(1, 1, 0, 8'h96, 0, 8, 0);
      check(t_rd_fall - t_wr_rise == EARLY_EXP, "R6 early read delay", t_rd_fall - t_wr_rise, EARLY_EXP);
      check(t_rd_rise - t_rd_fall == ACC_EXP, "R8 early read width", t_rd_rise - t_rd_fall, ACC_EXP);
      run(1, 1, 0, 8'h00, 0, 2, 0);
      check(t_rd_fall - t_wr_rise == EARLY_EXP, "R6 interrupt ignored", t_rd_fall - t_wr_rise, EARLY_EXP);

      // standalone, then standalone with fast also set
      run(1, 0, 1, 8'h71, 0, 20, 0);
      check(t_cs_fall == t_rd_fall, "R7 cs and rd low together", t_rd_fall, t_cs_fall);
      check(t_cs_rise - t_wr_rise == SOLO_EXP, "R7 settle delay", t_cs_rise - t_wr_rise, SOLO_EXP);
      check(n_rd_rises == 1 && n_wr_pulses == 1, "R7 single read and write", n_rd_rises, 1);
      run(1, 1, 1, 8'h0F, 0, 20, 0);
      check(t_cs_rise - t_wr_rise == SOLO_EXP, "R7 standalone overrides fast",
            t_cs_rise - t_wr_rise, SOLO_EXP);

      // timeouts: silent converter in both wait kinds
      run(0, 0, 0, 8'h00, 1, 10, 0);
      check(err == 1'b1, "R10 error after ready timeout", err, 1);
      run(1, 0, 0, 8'h00, 1, 10, 0);
      check(err == 1'b1, "R10 error after interrupt timeout", err, 1);
      check(cs_n && rd_n && wr_n, "R10 strobes released", {cs_n, rd_n, wr_n}, 7);
      run(1, 0, 0, 8'h81, 0, 15, 0);
      check(err == 1'b0, "R10 error cleared by new start", err, 0);

      // start while busy
      run(1, 1, 0, 8'h44, 0, 8, 1);
      repeat (20) @(negedge clk);
      check(n_wr_pulses == 1, "R11 second start ignored", n_wr_pulses, 1);
      check(sb.size() == 0, "R9 every expected result seen", sb.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule